// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block divides its clock by ten. Its state is a five-flop twisted ring: the inverted last stage shifts back into the first stage, so the register steps through ten codes. Each code is decoded into one of ten mutually exclusive outputs, and each decode is a two-input AND of two neighbouring register bits. A carry output is high for the first five counts and low for the last five, which gives a square wave at one tenth of the clock rate.

An active-high hold input stops advancement. An active-high clear input asynchronously forces the zero count. The release of clear is synchronised to the clock, so counting starts on a clean edge.

Only ten of the 32 possible register patterns are ring codes. The first-stage input is therefore gated with a validity term, so that any of the other 22 patterns drains back into the ring within a few advancing edges.

Top module: `decade_johnson_counter`

## Requirements
- R1: With hold low and the counter running, each rising edge moves the single active output from slot n to slot (n+1) mod 10. Slot n (n = 0..5) is the code with n ones filled in from bit 0 upward. Slot 5+k (k = 1..4) is the all-ones code with its k lowest bits cleared.
- R2: While hold is high, rising edges leave the register and every output unchanged. This includes an out-of-ring pattern, which is kept as it is.
- R3: While clear is high, and without waiting for a clock edge, slot 0 is high, slots 1 to 9 are low and carry is high, whatever the values of hold and the clock.
- R4: After clear falls, the count stays at slot 0 through the next two rising edges. The first advance happens on the third rising edge.
- R5: In every ring state exactly one of the ten decoded outputs is high. When advancing, each output stays high for exactly one clock period.
- R6: Carry is high while slot 0 to 4 is active and low while slot 5 to 9 is active. It is high for five cycles out of every ten.
- R7: From any of the 22 out-of-ring patterns, with hold low, the register reaches a ring code within at most four advancing edges. From then on it follows R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge |
| clr_i | input | 1 | Asynchronous clear to slot 0, active high |
| hold_i | input | 1 | Freezes the count while high |
| dec_o | output | 10 | One-hot decoded slot outputs, bit n is slot n |
| carry_o | output | 1 | Divide-by-ten carry, high for slots 0 to 4 |

## Verification
Decoded outputs and carry are combinational from the register. A change in hold therefore shows up on the first rising edge after it, and the bench drives inputs on falling edges and compares on the next falling edge, one register stage later. Clear needs no clock edge, so it is sampled one nanosecond after it rises. The release path holds the count for two edges, and the bench checks slot 0 after each of those edges and slot 1 after the third. For each of the 22 injected out-of-ring codes, the bench first confirms that the outputs stay frozen under hold. It then allows exactly four advancing edges, requires a one-hot result, and follows the rotation for ten further edges.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // Number of flops in the twisted ring; the decoded slot count is twice this.
  localparam int unsigned RING_STAGES = 5;
  // Flops in the clear-release synchroniser.
  localparam int unsigned SYNC_DEPTH  = 2;
endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync #(
  parameter int unsigned DEPTH = decade_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic clr_i,
  output logic run_o
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign run_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/decade_ring.sv
module decade_ring #(
  parameter int unsigned STAGES = decade_pkg::RING_STAGES
) (
  input  logic              clk_i,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [STAGES-1:0] state_o
);
  localparam int unsigned CW = $clog2(STAGES);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic [STAGES-2:0] seam_w;
  logic [CW-1:0]     seam_cnt;
  logic              in_ring;

  // A ring code has at most one place where neighbouring bits differ.
  for (genvar i = 0; i < STAGES - 1; i++) begin : g_seam
    assign seam_w[i] = state_q[i] ^ state_q[i+1];
  end

  always_comb begin
    seam_cnt = '0;
    for (int i = 0; i < STAGES - 1; i++) begin
      seam_cnt = seam_cnt + CW'(seam_w[i]);
    end
    in_ring = (seam_cnt <= CW'(1));
  end

  // Anti-lock: an out-of-ring pattern shifts zeros in until it is flushed.
  always_comb begin
    state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1] & in_ring};
  end

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      state_q <= '0;
    end else if (adv_i) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/decade_decode.sv
module decade_decode #(
  parameter int unsigned STAGES = decade_pkg::RING_STAGES
) (
  input  logic [STAGES-1:0]   state_i,
  output logic [2*STAGES-1:0] dec_o,
  output logic                carry_o
);
  for (genvar n = 0; n < 2 * STAGES; n++) begin : g_slot
    if (n == 0) begin : g_empty
      assign dec_o[n] = ~state_i[0] & ~state_i[STAGES-1];
    end else if (n < STAGES) begin : g_fill
      assign dec_o[n] = state_i[n-1] & ~state_i[n];
    end else if (n == STAGES) begin : g_full
      assign dec_o[n] = state_i[0] & state_i[STAGES-1];
    end else begin : g_drain
      assign dec_o[n] = ~state_i[n-STAGES-1] & state_i[n-STAGES];
    end
  end

  assign carry_o = ~state_i[STAGES-1];
endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter #(
  parameter int unsigned STAGES     = decade_pkg::RING_STAGES,
  parameter int unsigned SYNC_DEPTH = decade_pkg::SYNC_DEPTH
) (
  input  logic                clk_i,
  input  logic                clr_i,
  input  logic                hold_i,
  output logic [2*STAGES-1:0] dec_o,
  output logic                carry_o
);
  logic              run_w;
  logic              adv_w;
  logic [STAGES-1:0] state_w;

  decade_rst_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .clr_i (clr_i),
    .run_o (run_w)
  );

  assign adv_w = run_w & ~hold_i;

  decade_ring #(.STAGES(STAGES)) u_ring (
    .clk_i   (clk_i),
    .clr_i   (clr_i),
    .adv_i   (adv_w),
    .state_o (state_w)
  );

  decade_decode #(.STAGES(STAGES)) u_dec (
    .state_i (state_w),
    .dec_o   (dec_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/decade_checker.sv
module decade_checker #(
  parameter int unsigned STAGES = 5
) (
  input logic                clk_i,
  input logic                clr_i,
  input logic                hold_i,
  input logic                run_i,
  input logic [STAGES-1:0]   state_i,
  input logic [2*STAGES-1:0] dec_i,
  input logic                carry_i
);
  function automatic logic ring_code(input logic [STAGES-1:0] v);
    logic [STAGES-1:0] m;
    logic hit;
    m = '0;
    hit = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (v == m || v == ~m) hit = 1'b1;
      m = {m[STAGES-2:0], 1'b1};
    end
    return hit;
  endfunction

  logic       legal_w;
  logic       adv_w;
  logic [7:0] bad_cnt;

  assign legal_w = ring_code(state_i);
  assign adv_w   = run_i & ~hold_i;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      bad_cnt <= '0;
    end else if (legal_w) begin
      bad_cnt <= '0;
    end else if (adv_w && bad_cnt != 8'hFF) begin
      bad_cnt <= bad_cnt + 8'd1;
    end
  end

  p_advance_r1: assert property (@(posedge clk_i) disable iff (clr_i)
    (adv_w && legal_w) |=> dec_i == (($past(dec_i) << 1) | ($past(dec_i) >> (2*STAGES-1))));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    (!adv_w && legal_w) |=> (state_i == $past(state_i)) || !legal_w);

  always @(posedge clk_i) begin
    if (clr_i) begin
      p_clear_r3: assert (dec_i == (2*STAGES)'(1) && carry_i);
    end
  end

  p_release_r4: assert property (@(posedge clk_i) disable iff (clr_i)
    !run_i |=> state_i == '0);

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (clr_i)
    legal_w |-> $onehot(dec_i));

  p_carry_r6: assert property (@(posedge clk_i) disable iff (clr_i)
    legal_w |-> carry_i == (|dec_i[STAGES-1:0]));

  p_recover_r7: assert property (@(posedge clk_i) disable iff (clr_i)
    bad_cnt <= 8'(STAGES - 1));
endmodule

bind decade_johnson_counter decade_checker #(.STAGES(STAGES)) u_chk (
  .clk_i   (clk_i),
  .clr_i   (clr_i),
  .hold_i  (hold_i),
  .run_i   (run_w),
  .state_i (state_w),
  .dec_i   (dec_o),
  .carry_i (carry_o)
);

// File: tb/test_decade_johnson_counter.sv
`timescale 1ns/1ps
module test_decade_johnson_counter;
  logic       clk = 1'b0;
  logic       clr;
  logic       hold;
  logic [9:0] dec;
  logic       carry;
  logic [4:0] inj;

  int tests = 0;
  int fails = 0;
  int cnt   = 0;

  always #10 clk = ~clk;

  decade_johnson_counter i_decade_johnson_counter (
    .clk_i   (clk),
    .clr_i   (clr),
    .hold_i  (hold),
    .dec_o   (dec),
    .carry_o (carry)
  );

  task automatic check(input string req, input logic [9:0] exp_dec, input logic exp_carry);
    tests++;
    if (dec !== exp_dec || carry !== exp_carry) begin
      fails++;
      $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b", req, dec, carry, exp_dec, exp_carry);
    end
  endtask

  task automatic check_count(input string req);
    check(req, 10'b1 << cnt, cnt < 5);
  endtask

  function automatic logic is_ring(input int v);
    for (int k = 0; k < 5; k++) begin
      if (v == ((1 << k) - 1) || v == (31 ^ ((1 << k) - 1))) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(input logic h, input string req);
    hold = h;
    @(negedge clk);
    if (!h) cnt = (cnt + 1) % 10;
    check_count(req);
  endtask

  initial begin
    int high_cycles;
    int pos;
    logic [9:0] frozen;
    clr = 1'b1;
    hold = 1'b0;
    inj = '0;
    repeat (3) @(negedge clk);
    check("R3 reset state", 10'b1, 1'b1);
    hold = 1'b1;
    @(negedge clk);
    check("R3 reset overrides hold", 10'b1, 1'b1);

    // R4: release timing
    hold = 1'b0;
    clr = 1'b0;
    @(negedge clk);
    check("R4 zero after 1st edge", 10'b1, 1'b1);
    @(negedge clk);
    check("R4 zero after 2nd edge", 10'b1, 1'b1);
    @(negedge clk);
    cnt = 1;
    check_count("R4 first advance on 3rd edge");

    // R1/R5/R6: free-running sweep
    high_cycles = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, "R1 R5 advance");
      if (carry) high_cycles++;
    end
    tests++;
    if (high_cycles != 20) begin
      fails++;
      $display("FAIL R6 duty: high=%0d expected=20", high_cycles);
    end

    // R2: hold pattern
    for (int i = 0; i < 30; i++) begin
      step((i % 3) == 0, "R2 hold");
    end

    // R3: asynchronous clear in mid-count
    while (cnt == 0) step(1'b0, "R1 advance");
    #3 clr = 1'b1;
    #1 check("R3 async clear", 10'b1, 1'b1);
    @(negedge clk);
    check("R3 clear held over edge", 10'b1, 1'b1);
    clr = 1'b0;
    cnt = 0;
    @(negedge clk);
    check_count("R4 zero after release edge 1");
    @(negedge clk);
    check_count("R4 zero after release edge 2");
    step(1'b0, "R4 first advance after mid clear");

    // R7: recovery from every out-of-ring code
    for (int v = 0; v < 32; v++) begin
      if (!is_ring(v)) begin
        hold = 1'b1;
        @(negedge clk);
        inj = v[4:0];
        force i_decade_johnson_counter.u_ring.state_q = inj;
        #1 release i_decade_johnson_counter.u_ring.state_q;
        frozen = dec;
        repeat (2) @(negedge clk);
        check("R2 illegal code held", frozen, ~inj[4]);
        hold = 1'b0;
        repeat (4) @(negedge clk);
        tests++;
        if (!$onehot(dec)) begin
          fails++;
          $display("FAIL R7 code %0d not recovered: dec=%b expected one-hot", v, dec);
        end else begin
          pos = 0;
          for (int b = 0; b < 10; b++) if (dec[b]) pos = b;
          cnt = pos;
          for (int s = 0; s < 10; s++) step(1'b0, "R7 follows ring after recovery");
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule